// File: doc/BRIEF.md
# Dual-Phase Eight-Channel Circular Capture Recorder

This block records byte streams from eight receive channels into one on-chip memory that works as a circular buffer. Each memory word holds four channel bytes and four tag bits. One sample set (eight bytes) therefore needs two memory words. The block's clock runs at twice the sample rate. A sample strobe marks each new set of eight bytes. On the cycle the strobe arrives, the lower channel group is written. On the cycle after, the upper channel group is written from a hold register.

Recording runs while the run control is high and the block is not frozen. A freeze pulse stops new sample pairs from being written. A pair that has already started still completes, so the two words of a set always stay together. While the block is frozen, the write pointer and the wrap flag tell the host where the oldest entry is. The host reads words through a simple address/data port with a latency of one cycle. A read attempted while the block is not frozen returns zero and sets a sticky error flag. A rearm pulse clears the freeze, the error flag, the wrap flag and the pointer, and recording starts again from address zero.

Top module: `rec_pingpong`

## Requirements
- R1: During reset and directly after it, `wr_ptr_o` is 0 and `frozen_o`, `wrapped_o`, `rd_err_o`, `rd_valid_o` and `rd_data_o` are all 0.
- R2: When a strobe is accepted, the word written at the current pointer holds channel k (k = 0..3) in bits 8k+7:8k, and its bit 35 is 0.
- R3: On the next cycle, the word written at the following address holds channel 4+k in bits 8k+7:8k, and its bit 35 is 1. Strobes must be at least two cycles apart.
- R4: In every written word, bit 34 is the trigger marker captured with the sample. Bit 33 is 1 when at least one channel of that word's group was flagged valid. Bit 32 is 1 when all four were.
- R5: The write pointer advances by one for each word written. After address DEPTH-1 it returns to 0, and `wrapped_o` then stays 1.
- R6: After a freeze pulse, `frozen_o` is 1 and strobes write nothing. A second word that is still pending is written, and after that the pointer holds.
- R7: While `run_i` is 0, strobes write nothing and the pointer holds.
- R8: A read while frozen returns the word stored at `rd_addr_i`, one cycle later, together with `rd_valid_o`.
- R9: A read while not frozen returns 0 with `rd_valid_o`, and sets `rd_err_o`. The flag stays set until rearm.
- R10: A rearm pulse clears `frozen_o`, `rd_err_o`, `wrapped_o` and the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock, twice the sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_stb_i | input | 1 | New sample set present on channel inputs |
| ch_data_i | input | 64 | Eight channel bytes, channel n at bits 8n+7:8n |
| ch_vld_i | input | 8 | Per-channel valid flags |
| trig_i | input | 1 | Trigger-accept marker for this sample |
| run_i | input | 1 | Recording enable |
| freeze_i | input | 1 | Freeze request pulse |
| rearm_i | input | 1 | Restart pulse |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | 6 | Host read address |
| rd_data_o | output | 36 | Read word |
| rd_valid_o | output | 1 | Read data valid |
| rd_err_o | output | 1 | Sticky read-while-recording error |
| frozen_o | output | 1 | Recording stopped, memory readable |
| wr_ptr_o | output | 6 | Next write address |
| wrapped_o | output | 1 | Pointer has passed the end at least once |

## Verification
The hardest condition to reach is a freeze that arrives while the second half of a pair is still pending. The block must complete that word but refuse the next strobe. To reach it, the stimulus raises freeze on the idle cycle straight after a strobe and then sends another strobe while frozen. A wrap-around with the memory full is also hard to reach. The stimulus drives forty sample sets, which gives eighty words into sixty-four entries. It then freezes and reads every address, so that overwritten and fresh words are both compared against the reference model.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int TAG_W    = 4;
  localparam int TAG_GRP  = 3;
  localparam int TAG_TRIG = 2;
  localparam int TAG_ANY  = 1;
  localparam int TAG_ALL  = 0;

  function automatic logic [TAG_W-1:0] mk_tag(logic grp, logic trig, logic any_v, logic all_v);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_GRP]  = grp;
    t[TAG_TRIG] = trig;
    t[TAG_ANY]  = any_v;
    t[TAG_ALL]  = all_v;
    return t;
  endfunction
endpackage

// File: rtl/rec_seq.sv
module rec_seq
  import rec_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BYTE_W = 8,
  localparam int GRP_CH = NUM_CH / 2,
  localparam int DW     = GRP_CH * BYTE_W,
  localparam int WW     = DW + TAG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  logic                     rec_ok_i,
  input  logic [NUM_CH*BYTE_W-1:0] ch_data_i,
  input  logic [NUM_CH-1:0]        ch_vld_i,
  input  logic                     trig_i,
  output logic                     wr_en_o,
  output logic                     wr_grp_o,
  output logic                     pend_o,
  output logic [WW-1:0]            wr_word_o
);
  logic [DW-1:0]     hold_data_q;
  logic [GRP_CH-1:0] hold_vld_q;
  logic              hold_trig_q;
  logic              pend_q;
  logic              take;
  logic [DW-1:0]     lane_data;
  logic [GRP_CH-1:0] lane_vld;
  logic              lane_trig;

  assign take = stb_i & rec_ok_i & ~pend_q;

  // second half waits one cycle in the hold register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      hold_data_q <= '0;
      hold_vld_q  <= '0;
      hold_trig_q <= 1'b0;
    end else if (take) begin
      pend_q      <= 1'b1;
      hold_data_q <= ch_data_i[2*DW-1:DW];
      hold_vld_q  <= ch_vld_i[NUM_CH-1:GRP_CH];
      hold_trig_q <= trig_i;
    end else begin
      pend_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < GRP_CH; k++) begin : g_lane
    assign lane_data[k*BYTE_W +: BYTE_W] = pend_q ? hold_data_q[k*BYTE_W +: BYTE_W]
                                                  : ch_data_i[k*BYTE_W +: BYTE_W];
    assign lane_vld[k] = pend_q ? hold_vld_q[k] : ch_vld_i[k];
  end

  assign lane_trig = pend_q ? hold_trig_q : trig_i;
  assign wr_en_o   = pend_q | take;
  assign wr_grp_o  = pend_q;
  assign pend_o    = pend_q;
  assign wr_word_o = {mk_tag(pend_q, lane_trig, |lane_vld, &lane_vld), lane_data};
endmodule

// File: rtl/rec_ctrl.sv
module rec_ctrl #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              freeze_i,
  input  logic              rearm_i,
  input  logic              rd_en_i,
  output logic              frozen_o,
  output logic              wrapped_o,
  output logic              rd_err_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              frozen_q, wrapped_q, err_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q  <= 1'b0;
      wrapped_q <= 1'b0;
      err_q     <= 1'b0;
      ptr_q     <= '0;
    end else if (rearm_i) begin
      frozen_q  <= 1'b0;
      wrapped_q <= 1'b0;
      err_q     <= 1'b0;
      ptr_q     <= '0;
    end else begin
      if (freeze_i) frozen_q <= 1'b1;
      if (rd_en_i && !frozen_q) err_q <= 1'b1;
      if (wr_en_i) begin
        if (ptr_q == LAST) begin
          ptr_q     <= '0;
          wrapped_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign frozen_o  = frozen_q;
  assign wrapped_o = wrapped_q;
  assign rd_err_o  = err_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/rec_mem.sv
module rec_mem #(
  parameter int DEPTH = 64,
  parameter int WW    = 36,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WW-1:0]     rdata_o
);
  logic [WW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rec_pingpong.sv
module rec_pingpong
  import rec_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WW     = (NUM_CH / 2) * BYTE_W + TAG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_stb_i,
  input  logic [NUM_CH*BYTE_W-1:0] ch_data_i,
  input  logic [NUM_CH-1:0]        ch_vld_i,
  input  logic                     trig_i,
  input  logic                     run_i,
  input  logic                     freeze_i,
  input  logic                     rearm_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [WW-1:0]            rd_data_o,
  output logic                     rd_valid_o,
  output logic                     rd_err_o,
  output logic                     frozen_o,
  output logic [ADDR_W-1:0]        wr_ptr_o,
  output logic                     wrapped_o
);
  logic          rec_ok, wr_en, wr_grp, pend;
  logic [WW-1:0] wr_word, mem_rd;
  logic          rd_ok_q, rd_valid_q;

  assign rec_ok = run_i & ~frozen_o & ~freeze_i & ~rearm_i;

  rec_seq #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_seq (
    .clk_i, .rst_ni,
    .stb_i     (smp_stb_i),
    .rec_ok_i  (rec_ok),
    .ch_data_i, .ch_vld_i, .trig_i,
    .wr_en_o   (wr_en),
    .wr_grp_o  (wr_grp),
    .pend_o    (pend),
    .wr_word_o (wr_word)
  );

  rec_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .freeze_i, .rearm_i, .rd_en_i,
    .frozen_o, .wrapped_o, .rd_err_o,
    .ptr_o     (wr_ptr_o)
  );

  rec_mem #(.DEPTH(DEPTH), .WW(WW)) u_mem (
    .clk_i,
    .we_i    (wr_en),
    .waddr_i (wr_ptr_o),
    .wdata_i (wr_word),
    .raddr_i (rd_addr_i),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_ok_q    <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      rd_ok_q    <= rd_en_i & frozen_o;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_ok_q ? mem_rd : '0;
endmodule

// File: rtl/rec_pingpong_chk.sv
module rec_pingpong_chk #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_stb_i,
  input logic              run_i,
  input logic              rearm_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic              rd_err_o,
  input logic              frozen_o,
  input logic              wrapped_o,
  input logic [ADDR_W-1:0] wr_ptr_o,
  input logic              wr_en,
  input logic              wr_grp,
  input logic              pend
);
  assert_stb_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i |=> !smp_stb_i);

  assert_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !wr_grp) |=> (wr_en && wr_grp));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !rearm_i && wr_ptr_o != ADDR_W'(DEPTH - 1)) |=> wr_ptr_o == $past(wr_ptr_o) + 1'b1);

  assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !rearm_i && wr_ptr_o == ADDR_W'(DEPTH - 1)) |=> (wr_ptr_o == '0 && wrapped_o));

  assert_frozen_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !pend) |-> !wr_en);

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !pend) |-> !wr_en);

  assert_rd_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i));

  assert_rd_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_err_o) |-> $past(rd_en_i && !frozen_o));
endmodule

bind rec_pingpong rec_pingpong_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_stb_i  (smp_stb_i),
  .run_i      (run_i),
  .rearm_i    (rearm_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_err_o   (rd_err_o),
  .frozen_o   (frozen_o),
  .wrapped_o  (wrapped_o),
  .wr_ptr_o   (wr_ptr_o),
  .wr_en      (wr_en),
  .wr_grp     (wr_grp),
  .pend       (pend)
);

// File: tb/rec_pingpong_test.sv
module rec_pingpong_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 0, trig = 0, run = 0, freeze = 0, rearm = 0, rd_en = 0;
  logic [63:0] data = '0;
  logic [7:0]  vld = '0;
  logic [5:0]  rd_addr = '0;
  logic [35:0] rd_data;
  logic        rd_valid, rd_err, frozen, wrapped;
  logic [5:0]  wr_ptr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rec_pingpong uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .ch_data_i(data), .ch_vld_i(vld),
    .trig_i(trig), .run_i(run), .freeze_i(freeze), .rearm_i(rearm), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_err_o(rd_err),
    .frozen_o(frozen), .wr_ptr_o(wr_ptr), .wrapped_o(wrapped)
  );

  // behavioural reference
  logic [35:0] m_mem [64];
  int          m_ptr;
  bit          m_frz, m_err, m_wrap, m_pend, h_trig;
  logic [31:0] h_data;
  logic [3:0]  h_vld;
  bit          e_rv;
  logic [35:0] e_rd;

  task automatic m_adv();
    if (m_ptr == 63) begin m_ptr = 0; m_wrap = 1; end
    else m_ptr++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_frz = 0; m_err = 0; m_wrap = 0; m_pend = 0;
      e_rv = 0; e_rd = '0;
    end else begin
      bit nerr;
      e_rv = rd_en;
      e_rd = (rd_en && m_frz) ? m_mem[rd_addr] : 36'd0;
      nerr = m_err | (rd_en && !m_frz);
      if (m_pend) begin
        m_mem[m_ptr] = {1'b1, h_trig, |h_vld, &h_vld, h_data};
        m_adv();
        m_pend = 0;
      end else if (stb && run && !m_frz && !freeze && !rearm) begin
        m_mem[m_ptr] = {1'b0, trig, |vld[3:0], &vld[3:0], data[31:0]};
        m_adv();
        m_pend = 1; h_data = data[63:32]; h_vld = vld[7:4]; h_trig = trig;
      end
      m_err = nerr;
      if (freeze) m_frz = 1;
      if (rearm) begin m_frz = 0; m_err = 0; m_ptr = 0; m_wrap = 0; end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1 wr_ptr", 64'(wr_ptr), 64'd0);
        chk("R1 frozen", 64'(frozen), 64'd0);
        chk("R1 wrapped", 64'(wrapped), 64'd0);
        chk("R1 rd_err", 64'(rd_err), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);
      end else begin
        chk("R5 wr_ptr", 64'(wr_ptr), 64'(m_ptr));
        chk("R5 wrapped", 64'(wrapped), 64'(m_wrap));
        chk("R6 frozen", 64'(frozen), 64'(m_frz));
        chk("R9 rd_err", 64'(rd_err), 64'(m_err));
        chk("R8 rd_valid", 64'(rd_valid), 64'(e_rv));
        if (e_rv && !e_rd[35]) chk("R2 rd_data lanes", 64'(rd_data[31:0]), 64'(e_rd[31:0]));
        else if (e_rv)         chk("R3 rd_data lanes", 64'(rd_data[31:0]), 64'(e_rd[31:0]));
        else                   chk("R8 rd_data idle", 64'(rd_data[31:0]), 64'd0);
        chk("R4 rd_data tag", 64'(rd_data[35:32]), 64'(e_rd[35:32]));
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stb = 0; freeze = 0; rearm = 0; rd_en = 0;
    end
  endtask

  // one sample set: strobe cycle then a gap cycle (freeze optional on the gap)
  task automatic sample(int s, bit frz_gap);
    @(negedge clk);
    stb = 1; freeze = 0; rearm = 0; rd_en = 0;
    for (int k = 0; k < 8; k++) data[k*8 +: 8] = 8'((s * 37 + k * 11 + 5) & 255);
    vld  = (s % 3 == 0) ? 8'hFF : 8'((s * 13) ^ 8'hA5);
    trig = (s % 7 == 4);
    @(negedge clk);
    stb = 0; freeze = frz_gap;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    stb = 0; freeze = 0; rearm = 0; rd_en = 1; rd_addr = 6'(a);
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    stb = 0; freeze = 0; rd_en = 0; rearm = 1;
    @(negedge clk);
    rearm = 0;
    // R10: restart state
    chk("R10 frozen", 64'(frozen), 64'd0);
    chk("R10 rd_err", 64'(rd_err), 64'd0);
    chk("R10 wr_ptr", 64'(wr_ptr), 64'd0);
    chk("R10 wrapped", 64'(wrapped), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    run = 1;
    // R9: read while recording
    rd(3);
    idle(2);
    pulse_rearm();
    // short record, freeze while second half pending
    for (int s = 0; s < 10; s++) sample(s, s == 9);
    sample(50, 0);   // R6: strobe while frozen writes nothing
    idle(2);
    chk("R6 ptr held", 64'(wr_ptr), 64'd20);
    for (int a = 0; a < 20; a++) rd(a);
    idle(2);
    pulse_rearm();
    // wrap run: 80 words into 64 entries
    for (int s = 0; s < 40; s++) sample(s + 100, s == 39);
    idle(2);
    chk("R5 wrapped after fill", 64'(wrapped), 64'd1);
    chk("R5 ptr after wrap", 64'(wr_ptr), 64'd16);
    for (int a = 0; a < 64; a++) rd(a);
    idle(2);
    pulse_rearm();
    // R7: run low ignores strobes
    run = 0;
    for (int s = 0; s < 5; s++) sample(s + 200, 0);
    idle(2);
    chk("R7 ptr held with run low", 64'(wr_ptr), 64'd0);
    run = 1;
    for (int s = 0; s < 3; s++) sample(s + 300, s == 2);
    idle(2);
    for (int a = 0; a < 6; a++) rd(a);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule